// File: doc/BRIEF.md
# Alarm Interrupt and Square-Wave Output Selector

This block drives a single shared, active-low, open-drain output. It produces a single enable, `pin_oe`. When `pin_oe` is 1 the pad pulls the line low. When it is 0 the line is released. Two sources can use the line.

- **Square wave.** A programmable square wave is derived from a 32.768 kHz time base.
- **Alarm.** An alarm indication comes from an external time-compare unit.

A 4-bit select register controls the square wave. Code 0 turns the wave off. Any other code picks one of fifteen frequencies, and an active wave always owns the line.

With the wave off, the line shows the alarm in one of two styles. In pulse style each match strobe gives a low pulse of fixed length, which suits recurring alarms. In level style the line stays low for as long as the alarm status flag is set, which suits one-shot alarms.

A blanking control releases the line whenever the part runs from its backup battery. It acts only when its enable bit is also set.

The block is clocked at twice the base rate, 65.536 kHz. A half period at frequency f therefore lasts 32768/f clock cycles. This also lets the fastest setting toggle on every clock. The parameter `SCALE` shifts every half period right, with a floor of one cycle, so that slow settings can be reached in short runs. The parameter `PULSE_CYC` sets the pulse length. Its default of 16384 clock cycles equals 8192 base cycles, which is 250 ms.

Top module: `irq_fout_mux`

## Requirements
- R1: After reset the select register holds code 1, so `pin_oe` toggles every clock cycle.
- R2: For select codes 1 to 15 the output frequencies are 32768, 4096, 1024, 64, 32, 16, 8, 4, 2, 1, 1/2, 1/4, 1/8, 1/16 and 1/32 Hz. Each half period is 32768/f clock cycles, shifted right by `SCALE` with a floor of 1.
- R3: A write to the select register, strobed by `sel_wr`, takes effect at the next clock edge and restarts the divider. `pin_oe` is then 0 for exactly one half period before its first rise.
- R4: With select code 0 and no blanking, `pin_oe` equals the alarm indication.
- R5: With a non-zero select code and no blanking, `pin_oe` follows the square wave regardless of the alarm state.
- R6: In pulse style (`pulse_mode`=1), a one-cycle `alarm_match` strobe makes the alarm indication 1 for exactly `PULSE_CYC` cycles. In this style `alarm_flag` has no effect.
- R7: In level style (`pulse_mode`=0), the alarm indication equals `alarm_flag` in the same cycle. In this style `alarm_match` has no effect.
- R8: When `on_battery`=1 and `bat_blank`=1, `pin_oe` is 0 regardless of the other inputs.
- R9: If only one of `on_battery` and `bat_blank` is 1, there is no blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the 32.768 kHz base rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr | input | 1 | Select register write strobe |
| sel_wdata | input | 4 | New select code |
| pulse_mode | input | 1 | 1 selects pulse style, 0 selects level style |
| alarm_match | input | 1 | One-cycle alarm match strobe |
| alarm_flag | input | 1 | Alarm status flag |
| bat_blank | input | 1 | Enables blanking while on battery |
| on_battery | input | 1 | Backup supply is active |
| pin_oe | output | 1 | 1 pulls the shared line low |

## Verification
The bench builds the block with `SCALE`=6 and `PULSE_CYC`=40. With these values the slowest code, 1/32 Hz, has a half period of 16384 cycles. Every one of the fifteen frequency codes can then be timed over a full low and high phase in a single run. The short pulse lets the exact pulse length be counted cycle by cycle.

// File: rtl/irqfo_pkg.sv
package irqfo_pkg;
  localparam int EXP_TOP = 20;
  localparam int CNT_W   = EXP_TOP + 1;

  // log2 of the half period in clock cycles (clock = 2 x 32.768 kHz)
  function automatic int half_exp(input logic [3:0] code, input int scale);
    int e;
    case (code)
      4'd1:    e = 0;
      4'd2:    e = 3;
      4'd3:    e = 5;
      default: e = int'(code) + 5;
    endcase
    e = e - scale;
    if (e < 0) e = 0;
    return e;
  endfunction
endpackage

// File: rtl/fo_divider.sv
module fo_divider
  import irqfo_pkg::*;
#(
  parameter int SCALE = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] code,
  input  logic       restart,
  output logic       wave
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;
  logic             half_done;

  always_comb begin
    half_m1 = (CNT_W'(1) << half_exp(code, SCALE)) - CNT_W'(1);
  end

  assign half_done = (cnt >= half_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      wave <= 1'b0;
    end else if (restart) begin
      cnt  <= '0;
      wave <= 1'b0;
    end else if (half_done) begin
      cnt  <= '0;
      wave <= ~wave;
    end else begin
      cnt  <= cnt + CNT_W'(1);
    end
  end

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> cnt <= half_m1 || $past(restart)); // R2
  AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0) && !wave); // R3
endmodule

// File: rtl/alarm_shaper.sv
module alarm_shaper #(
  parameter int PULSE_CYC = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_mode,
  input  logic alarm_match,
  input  logic alarm_flag,
  output logic alarm_low
);
  localparam int PW = $clog2(PULSE_CYC + 1);

  logic [PW-1:0] pcnt;
  logic          pulse_act;
  logic          pulse_start;

  assign pulse_start = pulse_mode && alarm_match;
  assign pulse_act   = (pcnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pcnt <= '0;
    else if (pulse_start) pcnt <= PW'(PULSE_CYC);
    else if (pulse_act)   pcnt <= pcnt - PW'(1);
  end

  assign alarm_low = pulse_mode ? pulse_act : alarm_flag;

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_start |=> pulse_act); // R6
  AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_act && !pulse_start) |=> pcnt == $past(pcnt) - PW'(1)); // R6
endmodule

// File: rtl/irq_fout_mux.sv
module irq_fout_mux
  import irqfo_pkg::*;
#(
  parameter int SCALE     = 0,
  parameter int PULSE_CYC = 16384
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_wr,
  input  logic [3:0] sel_wdata,
  input  logic       pulse_mode,
  input  logic       alarm_match,
  input  logic       alarm_flag,
  input  logic       bat_blank,
  input  logic       on_battery,
  output logic       pin_oe
);
  logic [3:0] sel_q;
  logic       wave;
  logic       alarm_low;
  logic       blanked;
  logic       fo_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= 4'd1;
    else if (sel_wr) sel_q <= sel_wdata;
  end

  fo_divider #(.SCALE(SCALE)) u_div (
    .clk(clk), .rst_n(rst_n), .code(sel_q), .restart(sel_wr), .wave(wave)
  );

  alarm_shaper #(.PULSE_CYC(PULSE_CYC)) u_alm (
    .clk(clk), .rst_n(rst_n), .pulse_mode(pulse_mode),
    .alarm_match(alarm_match), .alarm_flag(alarm_flag), .alarm_low(alarm_low)
  );

  assign blanked = bat_blank && on_battery;
  assign fo_on   = (sel_q != 4'd0);

  always_comb begin
    if (blanked)    pin_oe = 1'b0;
    else if (fo_on) pin_oe = wave;
    else            pin_oe = alarm_low;
  end

  AST_BLANK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (on_battery && bat_blank) |-> !pin_oe); // R8
  AST_FREQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (fo_on && !blanked) |-> pin_oe == wave); // R5
  AST_ALARM_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (!fo_on && !blanked) |-> pin_oe == alarm_low); // R4
  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> sel_q == $past(sel_wdata)); // R3
endmodule

// File: tb/tb_irq_fout_mux.sv
module tb_irq_fout_mux;
  localparam int SCALE = 6;
  localparam int PULSE = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_wr = 1'b0;
  logic [3:0] sel_wdata = 4'd0;
  logic pulse_mode = 1'b0, alarm_match = 1'b0, alarm_flag = 1'b0;
  logic bat_blank = 1'b0, on_battery = 1'b0;
  logic pin_oe;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  irq_fout_mux #(.SCALE(SCALE), .PULSE_CYC(PULSE)) dut (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .pulse_mode(pulse_mode), .alarm_match(alarm_match), .alarm_flag(alarm_flag),
    .bat_blank(bat_blank), .on_battery(on_battery), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Half period from the frequency list: 32768/f cycles, scaled down.
  function automatic int exp_half(input int code);
    real f;
    int h;
    case (code)
      1: f = 32768.0;  2: f = 4096.0;  3: f = 1024.0;  4: f = 64.0;
      5: f = 32.0;     6: f = 16.0;    7: f = 8.0;     8: f = 4.0;
      9: f = 2.0;      10: f = 1.0;    11: f = 0.5;    12: f = 0.25;
      13: f = 0.125;   14: f = 0.0625; default: f = 0.03125;
    endcase
    h = int'(32768.0 / f) / (1 << SCALE);
    if (h < 1) h = 1;
    return h;
  endfunction

  task automatic write_sel(input logic [3:0] c);
    @(negedge clk); sel_wdata = c; sel_wr = 1'b1;
    @(negedge clk); sel_wr = 1'b0;
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (pin_oe == lvl && n < 40000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset;
    int prev;
    @(negedge clk);
    prev = pin_oe;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R1 toggle each cycle", pin_oe, 1 - prev);
      prev = pin_oe;
    end
  endtask

  task automatic t_codes;
    int lo, hi;
    for (int c = 1; c < 16; c++) begin
      write_sel(4'(c));
      run_len(1'b0, lo);
      check("R3 low run after write", lo, exp_half(c));
      run_len(1'b1, hi);
      check("R2 half period", hi, exp_half(c));
    end
  endtask

  task automatic t_level;
    write_sel(4'd0);
    pulse_mode = 1'b0; alarm_flag = 1'b1; #1;
    check("R4 R7 level flag set", pin_oe, 1);
    @(negedge clk); alarm_flag = 1'b0; #1;
    check("R7 level flag clear", pin_oe, 0);
    alarm_match = 1'b1; @(negedge clk); alarm_match = 1'b0; @(negedge clk);
    check("R7 match ignored in level", pin_oe, 0);
  endtask

  task automatic t_pulse;
    int n;
    pulse_mode = 1'b1; alarm_flag = 1'b1; @(negedge clk);
    check("R6 flag ignored in pulse", pin_oe, 0);
    alarm_flag = 1'b0;
    alarm_match = 1'b1; @(negedge clk); alarm_match = 1'b0;
    run_len(1'b1, n);
    check("R6 pulse width", n, PULSE);
    check("R6 after pulse", pin_oe, 0);
  endtask

  task automatic t_priority;
    int a, b;
    pulse_mode = 1'b0; alarm_flag = 1'b1;
    write_sel(4'd1);
    a = pin_oe; @(negedge clk); b = pin_oe;
    check("R5 wave wins over alarm", a + b, 1);
  endtask

  task automatic t_blank;
    int ones = 0;
    bat_blank = 1'b1; on_battery = 1'b0; write_sel(4'd0); #1;
    check("R9 blank bit alone", pin_oe, 1);
    bat_blank = 1'b0; on_battery = 1'b1; #1;
    check("R9 battery alone", pin_oe, 1);
    bat_blank = 1'b1; #1;
    check("R8 alarm blanked", pin_oe, 0);
    write_sel(4'd1);
    for (int i = 0; i < 8; i++) begin @(negedge clk); ones += pin_oe; end
    check("R8 wave blanked", ones, 0);
    bat_blank = 1'b0; on_battery = 1'b0; alarm_flag = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1; check("R1 reset released", pin_oe, 0);
    rst_n = 1'b1;
    t_reset();
    t_codes();
    t_level();
    t_pulse();
    t_priority();
    t_blank();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 190000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule